// File: doc/BRIEF.md
# Serial-to-Parallel Word Converter

This block turns a serial bit stream, delivered with its own bit clock, into parallel words and a word-rate clock. Every rising bit-clock edge moves the incoming bit into a shift row. Once every word, a holding row takes a copy of the whole shift row in one step, so the parallel bus changes once per word and stays put in between.

A free-running counter in the bit-clock domain divides the bit clock down to the word clock and marks the last bit of each word. Every flop in the block runs on the bit clock. The word clock is a registered output, not a rippled derived clock. A one-cycle valid strobe comes with each new word. With the default 8-bit word, a 10 Mbit/s input gives 1.25 Mword/s out.

There is no framing or start-pattern search. Word boundaries are counted from the release of reset. A downstream consumer either samples the bus on the valid strobe or on the rising edge of the word clock, which lands in the middle of each word's hold time.

Top module: `s2p_word_conv`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is sampled low, the next bit-clock edge clears the parallel word, the valid strobe and the word clock to 0.
- R2: `sdi` is sampled only on the rising edge of `bit_clk`, one bit per edge.
- R3: With the default ordering, the earliest bit of a word appears on `word_o[7]` and the latest on `word_o[0]`, so the byte value is the bits read MSB first.
- R4: After reset is released, the first word, made of the bits sampled on edges 1 to 8, appears on `word_o` right after edge 8. `word_vld_o` is 1 in that same cycle.
- R5: Later words follow back to back every 8 bit clocks (after edges 16, 24, …), none lost and none repeated.
- R6: `word_vld_o` is high for exactly one bit-clock cycle per word.
- R7: `word_o` does not change in any cycle that has no word update, even though the shift row moves on every edge.
- R8: `word_clk_o` has a period of 8 bit clocks and a 50 % duty cycle. Counting n edges since reset release, it is 1 when n mod 8 is 4 to 7 and 0 otherwise. It therefore falls together with each word update.
- R9: A reset applied in the middle of a word drops the partial word, and framing restarts from the new release of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; every flop uses its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial data in |
| word_o | output | 8 | Parallel word from the holding row |
| word_clk_o | output | 1 | Word-rate clock, bit clock divided by 8 |
| word_vld_o | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench sends byte values that show a wrong ordering at once: all zeros, all ones, single set bits at either end, and alternating patterns. A converter that shifts the wrong way outputs the bit-reversed byte. A snapshot taken one edge early or late gives a word shifted by one bit and mixed with its neighbour.

The bench checks the bus in every cycle between updates. A holding row that tracked the shift row would show moving bits there. A reset inserted after a few stray bits tests that framing is counted again from the release. A counter that was not cleared would put the next word at the wrong cycle, and the word clock phase is compared against the cycle count throughout.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

   // true when v is a power of two and at least 2
   function automatic bit is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/s2p_shift_row.sv
module s2p_shift_row #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sdi,
   output logic [W-1:0] row_q,
   output logic [W-1:0] row_nxt
);

   generate
      if (MSB_FIRST) begin : g_toward_msb
         assign row_nxt = {row_q[W-2:0], sdi};

         // R2
         newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> row_q[0] == $past(sdi));
         // R3
         shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> row_q[1] == $past(row_q[0]));
      end else begin : g_toward_lsb
         assign row_nxt = {sdi, row_q[W-1:1]};

         // R2
         newest_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> row_q[W-1] == $past(sdi));
         // R3
         shift_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> row_q[W-2] == $past(row_q[W-1]));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_nxt;
   end

endmodule

// File: rtl/s2p_hold_row.sv
module s2p_hold_row #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   // R4
   hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d));

endmodule

// File: rtl/s2p_word_div.sv
module s2p_word_div #(
   parameter int W = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic last_bit,
   output logic wclk_q
);

   localparam int CW = $clog2(W);

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nxt;

   assign cnt_nxt  = cnt + 1'b1;
   assign last_bit = &cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         wclk_q <= 1'b0;
      end else begin
         cnt    <= cnt_nxt;
         wclk_q <= cnt_nxt[CW-1];
      end
   end

   // R8
   wclk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_bit |=> $fell(wclk_q));

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_bit |=> cnt == '0);

endmodule

// File: rtl/s2p_word_conv.sv
module s2p_word_conv #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         bit_clk,
   input  logic         rst_n,
   input  logic         sdi,
   output logic [W-1:0] word_o,
   output logic         word_clk_o,
   output logic         word_vld_o
);

   import s2p_pkg::*;

   initial begin
      width_pow2_chk: assert (is_pow2(W))
         else $fatal(1, "word width must be a power of two of at least 2");
   end

   logic [W-1:0] shift_q;
   logic [W-1:0] shift_nxt;
   logic         last_bit;
   logic         vld_q;

   s2p_shift_row #(.W(W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk     (bit_clk),
      .rst_n   (rst_n),
      .sdi     (sdi),
      .row_q   (shift_q),
      .row_nxt (shift_nxt)
   );

   s2p_hold_row #(.W(W)) u_hold (
      .clk   (bit_clk),
      .rst_n (rst_n),
      .load  (last_bit),
      .d     (shift_nxt),
      .q     (word_o)
   );

   s2p_word_div #(.W(W)) u_div (
      .clk      (bit_clk),
      .rst_n    (rst_n),
      .last_bit (last_bit),
      .wclk_q   (word_clk_o)
   );

   always_ff @(posedge bit_clk) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= last_bit;
   end

   assign word_vld_o = vld_q;

   // R6
   vld_single_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

   // R8
   vld_wclk_low_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
      word_vld_o |-> !word_clk_o);

   // R1
   reset_clear_chk: assert property (@(posedge bit_clk)
      !rst_n |=> (word_o == '0) && !word_vld_o && !word_clk_o);

endmodule

// File: tb/tb_s2p_word_conv.sv
module tb_s2p_word_conv;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sdi = 1'b0;
   logic [7:0] word;
   logic       wclk;
   logic       vld;

   int         errors = 0;
   int         checks = 0;
   int         n = 0;
   logic       rst_at_edge = 1'b1;
   logic [7:0] exp_last = 8'h00;
   logic [7:0] exp_q[$];

   always #10 clk = ~clk;

   s2p_word_conv dut (
      .bit_clk    (clk),
      .rst_n      (rst_n),
      .sdi        (sdi),
      .word_o     (word),
      .word_clk_o (wclk),
      .word_vld_o (vld)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at t=%0t actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // driver: queue the byte, then shift it out MSB first (R3)
   task automatic send_byte(input logic [7:0] b);
      exp_q.push_back(b);
      for (int i = 7; i >= 0; i--) begin
         sdi = b[i];
         @(negedge clk);
      end
   endtask

   // edge count since reset release
   always @(posedge clk) begin
      rst_at_edge <= !rst_n;
      if (!rst_n) n <= 0;
      else        n <= n + 1;
   end

   // monitor: compares outputs away from the active edge
   always @(negedge clk) begin
      if (rst_at_edge) begin
         // R1
         chk(word == 8'h00 && !vld && !wclk, "R1", {word, 7'b0, vld, 7'b0, wclk}, 32'h0);
         exp_last = 8'h00;
      end else begin
         automatic bit exp_v = (n > 0) && (n % 8 == 0);
         automatic bit exp_c = (n % 8) >= 4;
         // R4 R6
         chk(vld == exp_v, "R4/R6 strobe", vld, exp_v);
         // R8
         chk(wclk == exp_c, "R8 word clock", wclk, exp_c);
         if (exp_v) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected word", word, 0);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               // R3 R5
               chk(word == e, "R3/R5 word value", word, e);
               exp_last = e;
            end
         end else begin
            // R7
            chk(word == exp_last, "R7 word held", word, exp_last);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 R3 R4 R5: edge patterns
      send_byte(8'h00);
      send_byte(8'hFF);
      send_byte(8'h80);
      send_byte(8'h01);
      send_byte(8'hA5);
      send_byte(8'h5A);
      send_byte(8'h3C);
      for (int k = 0; k < 20; k++) send_byte(8'((k * 37 + 11) & 8'hFF));
      // R9: stray partial word, then reset mid-stream
      sdi = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      send_byte(8'hC3);
      send_byte(8'h7E);
      @(negedge clk);
      @(negedge clk);
      // R5: every queued word came out
      chk(exp_q.size() == 0, "R5 words drained", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule